// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block decides which of three operating states a small microcontroller is in: run, standby or sleep. The processor can execute only in run. Software asks for a low-power state by writing a code to a mode register. The block then moves through a one-cycle entry step and drives the supply, oscillator, analog and processor-pause controls for the chosen state. The regulators, oscillator, RTC and processor sit outside the block, which drives them only through enable lines.

The block returns to run when an enabled wakeup event arrives: an RTC alarm, or one of four external lines that pass through a two-flop synchronizer. The two low-power states exit in different ways. Leaving standby resumes execution with nothing lost. Leaving sleep holds a system reset for the whole stabilization wait, so the processor restarts from its boot program. On either exit, a programmable settling count must elapse before the processor pause or the reset is released. A retention register keeps its contents through the sleep-exit reset, and only power-on reset clears it.

Top module: `pwr_mode_seq`

## Requirements
- R1: After power-on reset the block is in run with state code 0: `vddd_en_o`=1, `vddd_low_o`=0, `osc_en_o`=1, `cpu_pause_o`=0, `sys_rst_o`=0, `ana_en_o`=0, the settle register reads 4 and the retention register reads 0.
- R2: The mode register is at address 0. From run, writing 1 in bits [1:0] requests standby and writing 2 requests sleep. Writing 0 or 3 leaves the block in run. A request passes one cycle in the entry step (state code 1), then reaches standby (code 2) or sleep (code 3). Reading address 0 returns the state code in bits [2:0], and code 4 means settling.
- R3: In standby, `vddd_en_o`=1, `vddd_low_o`=1, `osc_en_o`=0 and `cpu_pause_o`=1.
- R4: In sleep, `vddd_en_o`=0, `vddd_low_o`=0, `osc_en_o`=0 and `cpu_pause_o`=1.
- R5: `ana_en_o` equals the analog configuration register (address 3, bits [5:0]) in run. It is 0 in the entry step, in both low-power states and while settling.
- R6: The wake configuration register is at address 1. Bit 0 runs the RTC, bit 1 enables its alarm, bit 2 enables the wakeup controller, and bits [6:3] enable external lines 0..3. An alarm wakes the block only on a rising edge with bits 0 and 1 set. An external line wakes it only on a rising edge after synchronization, with its own enable bit and bit 2 set. A masked edge neither wakes the block nor sets a flag.
- R7: The wake flag register is at address 2. Bit 0 is set by an alarm event and bit 1+i by an event on external line i. A flag stays set until software writes 1 to that bit; writing 0 leaves it set.
- R8: A wake event present during the entry step aborts the request, and the block goes back to run instead of entering the low-power state.
- R9: After a wake, the block settles for exactly N+1 cycles, where N is the settle register (address 4). While settling, `vddd_en_o`=1, `vddd_low_o`=0, `osc_en_o`=1 and `cpu_pause_o`=1. The block then returns to run.
- R10: Leaving standby never asserts `sys_rst_o`, and the analog configuration register keeps its value.
- R11: Leaving sleep asserts `sys_rst_o` in every settling cycle and drops it on return to run. That reset clears the analog configuration register to 0.
- R12: The retention register (address 5, 32 bits) keeps its value across the sleep-exit reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from address |
| ext_wake_i | input | 4 | External wakeup event lines, asynchronous |
| rtc_alarm_i | input | 1 | RTC alarm, synchronous to clk |
| vddd_en_o | output | 1 | Digital regulator enable |
| vddd_low_o | output | 1 | Digital regulator reduced-voltage select |
| osc_en_o | output | 1 | Internal oscillator enable |
| ana_en_o | output | 6 | Analog and sensor supply/reference enables |
| cpu_pause_o | output | 1 | Processor execution pause |
| sys_rst_o | output | 1 | System reset toward the processor domain |
| rtc_en_o | output | 1 | RTC run enable |
| alarm_en_o | output | 1 | RTC alarm enable |
| wkc_en_o | output | 1 | Wakeup controller enable |

## Verification
The bench goes after the edge cases where the two exit paths differ. A design that mixed them up would pulse reset after standby, or leave the analog configuration in place after sleep and so power sensors that software believes are off. It places an external edge so that it is recognized during the single entry cycle. A design without the abort window would then sleep through an event that has already happened. It counts settling cycles against the settle register, which exposes a counter that is off by one and releases the pause before the oscillator is stable. It also pulses masked lines with the wakeup controller or the per-line enable off. A design that gated wrongly would wake or set a flag there.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [2:0] {
        PM_RUN    = 3'd0,
        PM_ENTER  = 3'd1,
        PM_STBY   = 3'd2,
        PM_SLEEP  = 3'd3,
        PM_SETTLE = 3'd4
    } pm_state_e;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_WCFG   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_ANA    = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_SETTLE = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_RETAIN = 3'd5;

    localparam logic [1:0] REQ_STBY  = 2'd1;
    localparam logic [1:0] REQ_SLEEP = 2'd2;

endpackage

// File: rtl/pms_wake.sv
module pms_wake #(
    parameter int unsigned NUM_EXT = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [NUM_EXT-1:0] ext_i,
    input  logic [NUM_EXT-1:0] ext_en_i,
    input  logic               wkc_en_i,
    input  logic               rtc_alarm_i,
    input  logic               alarm_en_i,
    input  logic [NUM_EXT:0]   clr_i,
    output logic [NUM_EXT:0]   flags_o,
    output logic               wake_o
);

    localparam int unsigned FLAG_W = NUM_EXT + 1;

    typedef struct packed {
        logic [NUM_EXT-1:0] s1;
        logic [NUM_EXT-1:0] s2;
        logic [NUM_EXT-1:0] prev;
        logic               alarm_prev;
        logic [FLAG_W-1:0]  flags;
    } wake_s;

    wake_s q, d;
    logic [FLAG_W-1:0] evt;
    logic [FLAG_W-1:0] enmask;

    assign evt[0]    = rtc_alarm_i & ~q.alarm_prev & alarm_en_i;
    assign enmask[0] = alarm_en_i;

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_line
        assign evt[i+1]    = q.s2[i] & ~q.prev[i] & ext_en_i[i] & wkc_en_i;
        assign enmask[i+1] = ext_en_i[i] & wkc_en_i;
    end

    always_comb begin
        d            = q;
        d.s1         = ext_i;
        d.s2         = q.s1;
        d.prev       = q.s2;
        d.alarm_prev = rtc_alarm_i;
        d.flags      = (q.flags & ~clr_i) | evt;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    assign flags_o = q.flags;
    assign wake_o  = |evt;

    // R7: a set flag survives every cycle in which it is not cleared
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> ((q.flags & $past(q.flags & ~clr_i)) == $past(q.flags & ~clr_i)));

    // R6: a flag can only rise for a source that was enabled
    assert_masked_no_flag_R6: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (((q.flags & ~$past(q.flags)) & ~$past(enmask)) == '0));

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
    import pms_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             req_stby_i,
    input  logic             req_sleep_i,
    input  logic             wake_i,
    input  logic [CNT_W-1:0] settle_i,
    output pm_state_e        state_o,
    output logic             vddd_en_o,
    output logic             vddd_low_o,
    output logic             osc_en_o,
    output logic             cpu_pause_o,
    output logic             ana_gate_o,
    output logic             sys_rst_o
);

    typedef struct packed {
        pm_state_e        state;
        logic             target_sleep;
        logic             from_sleep;
        logic [CNT_W-1:0] cnt;
    } fsm_s;

    fsm_s q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            PM_RUN: begin
                if (req_stby_i || req_sleep_i) begin
                    d.state        = PM_ENTER;
                    d.target_sleep = req_sleep_i;
                end
            end
            PM_ENTER: begin
                if (wake_i)              d.state = PM_RUN;
                else if (q.target_sleep) d.state = PM_SLEEP;
                else                     d.state = PM_STBY;
            end
            PM_STBY, PM_SLEEP: begin
                if (wake_i) begin
                    d.state      = PM_SETTLE;
                    d.from_sleep = (q.state == PM_SLEEP);
                    d.cnt        = settle_i;
                end
            end
            PM_SETTLE: begin
                if (q.cnt == '0) begin
                    d.state      = PM_RUN;
                    d.from_sleep = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.state = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '{state: PM_RUN, target_sleep: 1'b0, from_sleep: 1'b0, cnt: '0};
        else        q <= d;
    end

    always_comb begin
        vddd_en_o   = 1'b1;
        vddd_low_o  = 1'b0;
        osc_en_o    = 1'b1;
        cpu_pause_o = 1'b1;
        ana_gate_o  = 1'b0;
        sys_rst_o   = 1'b0;
        unique case (q.state)
            PM_RUN: begin
                cpu_pause_o = 1'b0;
                ana_gate_o  = 1'b1;
            end
            PM_STBY: begin
                vddd_low_o = 1'b1;
                osc_en_o   = 1'b0;
            end
            PM_SLEEP: begin
                vddd_en_o = 1'b0;
                osc_en_o  = 1'b0;
            end
            PM_SETTLE: sys_rst_o = q.from_sleep;
            default: ;
        endcase
    end

    assign state_o = q.state;

    // R2: a low-power state is only reached through the entry step
    assert_entry_path_R2: assert property (@(posedge clk) disable iff (!por_n)
        ((q.state == PM_STBY || q.state == PM_SLEEP) &&
         !($past(q.state) == PM_STBY || $past(q.state) == PM_SLEEP))
        |-> $past(q.state) == PM_ENTER);

    // R8: a wake during entry sends the block back to run
    assert_abort_to_run_R8: assert property (@(posedge clk) disable iff (!por_n)
        (q.state == PM_ENTER && wake_i) |=> q.state == PM_RUN);

    // R9: settling continues while count remains
    assert_settle_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
        (q.state == PM_SETTLE && q.cnt != '0) |=> q.state == PM_SETTLE);

    // R10: nothing after standby raises the reset
    assert_stby_no_reset_R10: assert property (@(posedge clk) disable iff (!por_n)
        (q.state == PM_STBY) |=> !sys_rst_o);

    // R11: reset is released only on the move back to run
    assert_reset_release_R11: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst_o) |-> (q.state == PM_RUN && $past(q.state) == PM_SETTLE));

endmodule

// File: rtl/pms_regs.sv
module pms_regs
    import pms_pkg::*;
#(
    parameter int unsigned NUM_EXT    = 4,
    parameter int unsigned ANA_W      = 6,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SETTLE_RST = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  pm_state_e         state_i,
    input  logic [NUM_EXT:0]  flags_i,
    input  logic              sys_rst_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              req_stby_o,
    output logic              req_sleep_o,
    output logic              rtc_en_o,
    output logic              alarm_en_o,
    output logic              wkc_en_o,
    output logic [NUM_EXT-1:0] ext_en_o,
    output logic [NUM_EXT:0]  clr_o,
    output logic [ANA_W-1:0]  ana_cfg_o,
    output logic [CNT_W-1:0]  settle_o
);

    localparam int unsigned WCFG_W = 3 + NUM_EXT;

    typedef struct packed {
        logic [WCFG_W-1:0] wcfg;
        logic [ANA_W-1:0]  ana;
        logic [CNT_W-1:0]  settle;
        logic [DATA_W-1:0] retain;
    } regs_s;

    regs_s q, d;
    logic  wr_mode;

    assign wr_mode     = wr_en_i && (addr_i == ADDR_MODE);
    assign req_stby_o  = wr_mode && (wdata_i[1:0] == REQ_STBY);
    assign req_sleep_o = wr_mode && (wdata_i[1:0] == REQ_SLEEP);
    assign clr_o       = (wr_en_i && addr_i == ADDR_FLAGS) ? wdata_i[NUM_EXT:0] : '0;

    always_comb begin
        d = q;
        if (wr_en_i) begin
            unique case (addr_i)
                ADDR_WCFG:   d.wcfg   = wdata_i[WCFG_W-1:0];
                ADDR_ANA:    d.ana    = wdata_i[ANA_W-1:0];
                ADDR_SETTLE: d.settle = wdata_i[CNT_W-1:0];
                ADDR_RETAIN: d.retain = wdata_i;
                default: ;
            endcase
        end
        if (sys_rst_i) d.ana = '0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '{wcfg: '0, ana: '0, settle: CNT_W'(SETTLE_RST), retain: '0};
        else        q <= d;
    end

    always_comb begin
        unique case (addr_i)
            ADDR_MODE:   rdata_o = DATA_W'(state_i);
            ADDR_WCFG:   rdata_o = DATA_W'(q.wcfg);
            ADDR_FLAGS:  rdata_o = DATA_W'(flags_i);
            ADDR_ANA:    rdata_o = DATA_W'(q.ana);
            ADDR_SETTLE: rdata_o = DATA_W'(q.settle);
            ADDR_RETAIN: rdata_o = q.retain;
            default:     rdata_o = '0;
        endcase
    end

    assign rtc_en_o   = q.wcfg[0];
    assign alarm_en_o = q.wcfg[1];
    assign wkc_en_o   = q.wcfg[2];
    assign ext_en_o   = q.wcfg[3 +: NUM_EXT];
    assign ana_cfg_o  = q.ana;
    assign settle_o   = q.settle;

    // R12: only a direct write changes the retention register
    assert_retain_kept_R12: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_en_i && addr_i == ADDR_RETAIN) |=> $stable(q.retain));

    // R11: the system reset empties the analog configuration
    assert_ana_cleared_R11: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_i |=> q.ana == '0);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int unsigned NUM_EXT    = 4,
    parameter int unsigned ANA_W      = 6,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SETTLE_RST = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               bus_wr_i,
    input  logic [2:0]         bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    input  logic [NUM_EXT-1:0] ext_wake_i,
    input  logic               rtc_alarm_i,
    output logic               vddd_en_o,
    output logic               vddd_low_o,
    output logic               osc_en_o,
    output logic [ANA_W-1:0]   ana_en_o,
    output logic               cpu_pause_o,
    output logic               sys_rst_o,
    output logic               rtc_en_o,
    output logic               alarm_en_o,
    output logic               wkc_en_o
);

    pm_state_e          state;
    logic               req_stby, req_sleep, wake, ana_gate;
    logic [NUM_EXT-1:0] ext_en;
    logic [NUM_EXT:0]   flags, clr;
    logic [ANA_W-1:0]   ana_cfg;
    logic [CNT_W-1:0]   settle;

    pms_regs #(
        .NUM_EXT(NUM_EXT), .ANA_W(ANA_W), .CNT_W(CNT_W),
        .DATA_W(DATA_W), .SETTLE_RST(SETTLE_RST)
    ) u_regs (
        .clk(clk), .por_n(por_n),
        .wr_en_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
        .state_i(state), .flags_i(flags), .sys_rst_i(sys_rst_o),
        .rdata_o(bus_rdata_o), .req_stby_o(req_stby), .req_sleep_o(req_sleep),
        .rtc_en_o(rtc_en_o), .alarm_en_o(alarm_en_o), .wkc_en_o(wkc_en_o),
        .ext_en_o(ext_en), .clr_o(clr), .ana_cfg_o(ana_cfg), .settle_o(settle)
    );

    pms_wake #(.NUM_EXT(NUM_EXT)) u_wake (
        .clk(clk), .por_n(por_n),
        .ext_i(ext_wake_i), .ext_en_i(ext_en), .wkc_en_i(wkc_en_o),
        .rtc_alarm_i(rtc_alarm_i), .alarm_en_i(rtc_en_o & alarm_en_o),
        .clr_i(clr), .flags_o(flags), .wake_o(wake)
    );

    pms_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .por_n(por_n),
        .req_stby_i(req_stby), .req_sleep_i(req_sleep), .wake_i(wake),
        .settle_i(settle), .state_o(state),
        .vddd_en_o(vddd_en_o), .vddd_low_o(vddd_low_o), .osc_en_o(osc_en_o),
        .cpu_pause_o(cpu_pause_o), .ana_gate_o(ana_gate), .sys_rst_o(sys_rst_o)
    );

    assign ana_en_o = ana_cfg & {ANA_W{ana_gate}};

    // R5: no analog enable while the processor is paused
    assert_ana_off_paused_R5: assert property (@(posedge clk) disable iff (!por_n)
        cpu_pause_o |-> ana_en_o == '0);

endmodule

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [3:0]  ext_wake = 4'd0;
    logic        rtc_alarm = 1'b0;
    logic        vddd_en, vddd_low, osc_en, cpu_pause, sys_rst, rtc_en, alarm_en, wkc_en;
    logic [5:0]  ana_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwr_mode_seq u0 (
        .clk(clk), .por_n(por_n),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .ext_wake_i(ext_wake), .rtc_alarm_i(rtc_alarm),
        .vddd_en_o(vddd_en), .vddd_low_o(vddd_low), .osc_en_o(osc_en),
        .ana_en_o(ana_en), .cpu_pause_o(cpu_pause), .sys_rst_o(sys_rst),
        .rtc_en_o(rtc_en), .alarm_en_o(alarm_en), .wkc_en_o(wkc_en)
    );

    // [9:8] request code, [7:5] state, [4] vddd_en, [3] vddd_low, [2] osc, [1] pause
    localparam logic [9:0] VEC [4] = '{
        {2'd0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd1, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {2'd2, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'd3, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] dat);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = dat;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] dat);
        bus_addr = a;
        #1;
        dat = bus_rdata;
    endtask

    // called one cycle after the trigger; counts settle cycles
    task automatic measure(output int n, output int nrst);
        int k = 0;
        n = 0; nrst = 0;
        while (!osc_en && k < 10) begin @(negedge clk); k++; end
        while (cpu_pause && osc_en && n < 1000) begin
            n++;
            if (sys_rst) nrst++;
            if (!vddd_en || vddd_low || ana_en != 0) nrst += 1000;
            @(negedge clk);
        end
    endtask

    task automatic alarm_wake(output int n, output int nrst);
        rtc_alarm = 1'b1;
        @(negedge clk);
        rtc_alarm = 1'b0;
        measure(n, nrst);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int n, nrst;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 outputs", {vddd_en, vddd_low, osc_en, cpu_pause, sys_rst}, 5'b10100);
        chk("R1 ana_en", ana_en, 0);
        rd(3'd0, r); chk("R1 state", r, 0);
        rd(3'd4, r); chk("R1 settle reset", r, 4);
        rd(3'd5, r); chk("R1 retain reset", r, 0);

        wr(3'd1, 32'h3);
        chk("R6 rtc enables out", {rtc_en, alarm_en, wkc_en}, 3'b110);

        // R2 R3 R4 table walk
        for (int i = 0; i < 4; i++) begin
            wr(3'd0, {30'd0, VEC[i][9:8]});
            if (VEC[i][7:5] != 0) begin
                rd(3'd0, r); chk("R2 entry step", r, 1);
            end
            @(negedge clk);
            rd(3'd0, r); chk("R2 state after request", r, {29'd0, VEC[i][7:5]});
            chk("R3 R4 controls", {vddd_en, vddd_low, osc_en, cpu_pause},
                {28'd0, VEC[i][4:1]});
            chk("R5 ana off", ana_en, 0);
            if (VEC[i][7:5] != 0) begin
                alarm_wake(n, nrst);
                chk("R9 settle length", n, 5);
                rd(3'd0, r); chk("R9 back in run", r, 0);
            end
        end

        // R5 R10 standby round trip keeps analog config
        wr(3'd2, 32'h1f);
        wr(3'd3, 32'h2a);
        @(negedge clk);
        chk("R5 ana in run", ana_en, 6'h2a);
        wr(3'd0, 32'h1);
        @(negedge clk);
        chk("R5 ana off standby", ana_en, 0);
        alarm_wake(n, nrst);
        chk("R10 no reset on standby exit", nrst, 0);
        chk("R10 ana restored", ana_en, 6'h2a);
        rd(3'd2, r); chk("R7 alarm flag", r, 1);

        // R6 masked lines in standby
        wr(3'd2, 32'h1f);
        wr(3'd1, 32'h3 | 32'h4 | 32'h8);
        wr(3'd0, 32'h1);
        @(negedge clk);
        ext_wake[1] = 1'b1;
        repeat (6) @(negedge clk);
        ext_wake[1] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 line disabled keeps standby", {vddd_low, cpu_pause}, 2'b11);
        rd(3'd2, r); chk("R6 no flag for disabled line", r, 0);
        wr(3'd1, 32'h3 | 32'h8);
        ext_wake[0] = 1'b1;
        repeat (6) @(negedge clk);
        ext_wake[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 controller off keeps standby", {vddd_low, cpu_pause}, 2'b11);
        rd(3'd2, r); chk("R6 no flag controller off", r, 0);
        alarm_wake(n, nrst);
        chk("R9 settle after masked", n, 5);

        // R11 R12 sleep exit via external line 2
        wr(3'd2, 32'h1f);
        wr(3'd5, 32'hC0FFEE11);
        wr(3'd4, 32'd7);
        wr(3'd3, 32'h15);
        wr(3'd1, 32'h3 | 32'h4 | 32'h20);
        wr(3'd0, 32'h2);
        @(negedge clk);
        chk("R4 sleep regulator off", {vddd_en, osc_en}, 2'b00);
        ext_wake[2] = 1'b1;
        @(negedge clk);
        measure(n, nrst);
        ext_wake[2] = 1'b0;
        chk("R9 settle length 7", n, 8);
        chk("R11 reset each settle cycle", nrst, 8);
        chk("R11 reset released", sys_rst, 0);
        rd(3'd3, r); chk("R11 ana config cleared", r, 0);
        chk("R11 ana_en cleared", ana_en, 0);
        rd(3'd5, r); chk("R12 retention kept", r, 32'hC0FFEE11);

        // R7 sticky flags
        rd(3'd2, r); chk("R7 line2 flag", r, 32'h8);
        wr(3'd2, 32'h0);
        rd(3'd2, r); chk("R7 write zero keeps", r, 32'h8);
        wr(3'd2, 32'h8);
        rd(3'd2, r); chk("R7 write one clears", r, 0);

        // R8 abort during entry step
        wr(3'd1, 32'h3 | 32'h4 | 32'h8);
        repeat (3) @(negedge clk);
        ext_wake[0] = 1'b1;
        wr(3'd0, 32'h1);
        rd(3'd0, r); chk("R8 in entry step", r, 1);
        @(negedge clk);
        rd(3'd0, r); chk("R8 aborted to run", r, 0);
        chk("R8 pause released", cpu_pause, 0);
        repeat (3) @(negedge clk);
        chk("R8 still running", {vddd_low, cpu_pause}, 2'b00);
        rd(3'd2, r); chk("R8 line0 flag", r, 32'h2);
        ext_wake[0] = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule